// File: doc/BRIEF.md
# Printer Port Register Block

This block is the byte-wide register set of a legacy printer port. A host reaches it over a simple bus: a 3-bit offset, separate read and write strobes, and 8-bit data. It holds a latch for outgoing data, a latch for incoming data, a status register and a control register.

The printer handshake is modelled inside the block. Raising the strobe bit through a control write sends the outgoing byte out on a transmit output, marked by a one-cycle valid pulse. Each status read moves an acknowledge/busy sequence forward. A strobe-low control write, made while interrupts are enabled, raises an interrupt. The interrupt is cleared when the host reads status.

Top module: `ppRegs`

## Requirements
- R1: After reset, both data latches hold 0xFF, status reads 0xD8 (busy 0x80, ack 0x40, online 0x10, error-complement 0x08), control reads 0x0C (select-in 0x08, init 0x04), and irq, txValid are low with busRdata at 0xFF.
- R2: Offset 1 reads status and offset 2 reads control. Offsets 3 to 7 read 0xFF. Writes to offsets 1 and 3 to 7 change nothing.
- R3: A read of offset 0 returns the incoming-data latch when control bit 5 (direction) is 1, and the outgoing-data latch otherwise. A write to offset 0 loads the outgoing-data latch.
- R4: A control write stores the full written byte, after its side effects are evaluated against the previously stored value.
- R5: A control write with bit 2 (init) at 0 reloads status to 0xC0. Strobe handling is then applied on top of that value.
- R6: A control write with bit 0 (strobe) at 1 clears status busy. If the stored strobe bit was 0, txByte carries the outgoing latch with txValid high for exactly one cycle.
- R7: A control write with strobe at 0, while the stored control has bit 4 (interrupt enable) set, sets the pending flag. irq shows the flag from the cycle after that write.
- R8: A status read returns the status as it was before the read, and clears the pending flag.
- R9: On a status read with busy at 0 and stored strobe at 0, ack is cleared if it was set. If it was clear, ack and busy are both set.
- R10: A cycle with both busRd and busWr asserted performs only the write. busRdata keeps its value.
- R11: Read data appears on busRdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Register offset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| txByte | output | 8 | Byte launched by a strobe rise |
| txValid | output | 1 | One-cycle marker for txByte |
| irq | output | 1 | Interrupt request (pending flag) |

## Verification
The bench builds the block with its default reset values for both data latches (0xFF). This makes the reset image equal to the value unused offsets return, so a read of a wrong register is still caught through the outgoing latch, which the bench loads with other values. Random control bytes reach every combination of init, strobe, interrupt enable and direction. Long runs of status reads between them drive the ack/busy sequence through all its states.

// File: rtl/ppPkg.sv
package ppPkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_BUSY = 7;
  localparam int ST_ACK  = 6;
  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [DATA_W-1:0] STATUS_RESET = 8'hD8;
  localparam logic [DATA_W-1:0] STATUS_INIT  = 8'hC0;
  localparam logic [DATA_W-1:0] CTRL_RESET   = 8'h0C;
  localparam logic [DATA_W-1:0] UNMAPPED     = 8'hFF;

  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic rdData;
    logic rdStatus;
    logic rdCtrl;
    logic rdOther;
  } ppStrobes_t;
endpackage

// File: rtl/ppDecode.sv
module ppDecode
  import ppPkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output ppStrobes_t        strobes
);
  logic rdOnly;
  logic isData, isStat, isCtrl;

  always_comb begin
    // a write takes the cycle when both strobes are seen
    rdOnly = busRd && !busWr;
    isData = (busAddr == OFS_DATA);
    isStat = (busAddr == OFS_STAT);
    isCtrl = (busAddr == OFS_CTRL);

    strobes.wrData   = busWr && isData;
    strobes.wrCtrl   = busWr && isCtrl;
    strobes.rdData   = rdOnly && isData;
    strobes.rdStatus = rdOnly && isStat;
    strobes.rdCtrl   = rdOnly && isCtrl;
    strobes.rdOther  = rdOnly && !isData && !isStat && !isCtrl;
  end
endmodule

// File: rtl/ppDatapath.sv
module ppDatapath
  import ppPkg::*;
#(
  parameter logic [DATA_W-1:0] RD_RESET = 8'hFF,
  parameter logic [DATA_W-1:0] WR_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ppStrobes_t        strobes,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid,
  output logic              irq
);
  logic [DATA_W-1:0] wrLatchQ, rdLatchQ, statusQ, ctrlQ, rdDataQ;
  logic [DATA_W-1:0] statusN, ctrlN, rdMux;
  logic              pendQ, pendN, txFire, rdAny;

  // next state of the handshake registers
  always_comb begin
    statusN = statusQ;
    ctrlN   = ctrlQ;
    pendN   = pendQ;
    txFire  = 1'b0;
    if (strobes.wrCtrl) begin
      if (!busWdata[CT_INIT]) statusN = STATUS_INIT;
      if (busWdata[CT_STB]) begin
        statusN[ST_BUSY] = 1'b0;
        txFire = !ctrlQ[CT_STB];
      end else if (ctrlQ[CT_IEN]) begin
        pendN = 1'b1;
      end
      ctrlN = busWdata;
    end
    if (strobes.rdStatus) begin
      pendN = 1'b0;
      if (!statusQ[ST_BUSY] && !ctrlQ[CT_STB]) begin
        if (statusQ[ST_ACK]) begin
          statusN[ST_ACK] = 1'b0;
        end else begin
          statusN[ST_ACK]  = 1'b1;
          statusN[ST_BUSY] = 1'b1;
        end
      end
    end
  end

  // read selection
  always_comb begin
    rdAny = strobes.rdData || strobes.rdStatus || strobes.rdCtrl || strobes.rdOther;
    rdMux = UNMAPPED;
    if (strobes.rdData)        rdMux = ctrlQ[CT_DIR] ? rdLatchQ : wrLatchQ;
    else if (strobes.rdStatus) rdMux = statusQ;
    else if (strobes.rdCtrl)   rdMux = ctrlQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLatchQ <= WR_RESET;
      rdLatchQ <= RD_RESET;
      statusQ  <= STATUS_RESET;
      ctrlQ    <= CTRL_RESET;
      pendQ    <= 1'b0;
      rdDataQ  <= UNMAPPED;
      txByte   <= '0;
      txValid  <= 1'b0;
    end else begin
      if (strobes.wrData) wrLatchQ <= busWdata;
      statusQ <= statusN;
      ctrlQ   <= ctrlN;
      pendQ   <= pendN;
      if (rdAny) rdDataQ <= rdMux;
      txValid <= txFire;
      if (txFire) txByte <= wrLatchQ;
    end
  end

  assign busRdata = rdDataQ;
  assign irq      = pendQ;

  // R6
  tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> !txValid);

  // R6
  tx_strobe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (ctrlQ[CT_STB] && !statusQ[ST_BUSY]));

  // R8
  status_read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStatus |=> !irq);

  // R7
  irq_from_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strobes.wrCtrl));

  // R10
  rd_wr_collision_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busRd) |=> $stable(busRdata));

  // R2
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdOther |=> (busRdata == UNMAPPED));
endmodule

// File: rtl/ppRegs.sv
module ppRegs
  import ppPkg::*;
#(
  parameter logic [7:0] RD_RESET = 8'hFF,
  parameter logic [7:0] WR_RESET = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic [7:0] txByte,
  output logic       txValid,
  output logic       irq
);
  ppStrobes_t strobes;

  ppDecode i_decode (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobes (strobes)
  );

  ppDatapath #(
    .RD_RESET (RD_RESET),
    .WR_RESET (WR_RESET)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .txByte   (txByte),
    .txValid  (txValid),
    .irq      (irq)
  );
endmodule

// File: tb/test_ppRegs.sv
`timescale 1ns/1ps
module test_ppRegs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata, txByte;
  logic       txValid, irq;

  int passCount = 0;
  int totalCount = 0;
  bit finished = 0;

  // bench model state
  logic [7:0] mDw = 8'hFF, mSt = 8'hD8, mCt = 8'h0C, mRd = 8'hFF;
  logic       mPend = 1'b0;

  always #2 clk = ~clk;

  ppRegs i_ppRegs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .txByte(txByte),
    .txValid(txValid), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    totalCount++;
    if (act === exp) passCount++;
    else $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", passCount, totalCount);
      $finish;
    end
  endtask

  // one bus access, with the model stepped and outputs checked after it
  task automatic doOp(input logic w, input logic r, input logic [2:0] a,
                      input logic [7:0] d, input string req);
    logic expTx;
    logic [7:0] expTxB;
    expTx = 1'b0;
    expTxB = 8'h00;
    if (w) begin
      if (a == 3'd0) mDw = d;
      else if (a == 3'd2) begin
        if (!d[2]) mSt = 8'hC0;
        if (d[0]) begin
          mSt[7] = 1'b0;
          if (!mCt[0]) begin expTx = 1'b1; expTxB = mDw; end
        end else if (mCt[4]) mPend = 1'b1;
        mCt = d;
      end
    end else if (r) begin
      case (a)
        3'd0: mRd = mCt[5] ? 8'hFF : mDw;
        3'd1: begin
          mRd = mSt;
          mPend = 1'b0;
          if (!mSt[7] && !mCt[0]) begin
            if (mSt[6]) mSt[6] = 1'b0;
            else mSt = mSt | 8'hC0;
          end
        end
        3'd2: mRd = mCt;
        default: mRd = 8'hFF;
      endcase
    end
    @(negedge clk);
    busWr = w; busRd = r; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
    check({req, " rdata (R11)"}, busRdata, mRd);
    check({req, " irq (R7)"}, {7'd0, irq}, {7'd0, mPend});
    check({req, " txValid (R6)"}, {7'd0, txValid}, {7'd0, expTx});
    if (expTx) check({req, " txByte (R6)"}, txByte, expTxB);
  endtask

  initial begin
    #400000;
    totalCount++;
    $display("FAIL watchdog: actual running expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    check("R1 rdata", busRdata, 8'hFF);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 txValid", {7'd0, txValid}, 8'h00);
    doOp(0, 1, 3'd1, 8'h00, "R1 status");
    check("R1 status value", busRdata, 8'hD8);
    doOp(0, 1, 3'd2, 8'h00, "R1 control");
    check("R1 control value", busRdata, 8'h0C);
    doOp(0, 1, 3'd0, 8'h00, "R1 data");
    // R2 unmapped offsets and ignored writes
    for (int k = 3; k < 8; k++) doOp(0, 1, 3'(k), 8'h00, "R2 unmapped");
    doOp(1, 0, 3'd5, 8'h00, "R2 ignored write");
    doOp(1, 0, 3'd1, 8'h00, "R2 status write");
    doOp(0, 1, 3'd1, 8'h00, "R2 status after write");
    // R3 direction
    doOp(1, 0, 3'd0, 8'h5A, "R3 load");
    doOp(0, 1, 3'd0, 8'h00, "R3 dir out");
    check("R3 data value", busRdata, 8'h5A);
    doOp(1, 0, 3'd2, 8'h2C, "R3 dir in");
    doOp(0, 1, 3'd0, 8'h00, "R3 read in latch");
    doOp(0, 1, 3'd2, 8'h00, "R4 control readback");
    check("R4 control value", busRdata, 8'h2C);
    // R6 strobe rise, then no repeat
    doOp(1, 0, 3'd2, 8'h0D, "R6 strobe rise");
    doOp(1, 0, 3'd2, 8'h0D, "R6 strobe held");
    doOp(0, 1, 3'd1, 8'h00, "R6 busy cleared");
    // R7 R8 R9 interrupt and ack sequence
    doOp(1, 0, 3'd2, 8'h1C, "R7 enable");
    doOp(1, 0, 3'd2, 8'h1C, "R7 pend");
    check("R7 irq high", {7'd0, irq}, 8'h01);
    doOp(0, 1, 3'd1, 8'h00, "R8 clear");
    for (int k = 0; k < 4; k++) doOp(0, 1, 3'd1, 8'h00, "R9 toggle");
    // R5 init reload with strobe rise
    doOp(1, 0, 3'd0, 8'hA7, "R5 load");
    doOp(1, 0, 3'd2, 8'h19, "R5 init");
    doOp(0, 1, 3'd1, 8'h00, "R5 status");
    check("R5 status value", busRdata, 8'h40);
    // R10 collision
    doOp(1, 1, 3'd0, 8'h33, "R10 collide");
    doOp(1, 1, 3'd2, 8'h1C, "R10 collide ctrl");
    doOp(0, 1, 3'd0, 8'h00, "R10 after");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int sel;
      logic [7:0] d;
      sel = $urandom % 10;
      d = 8'($urandom);
      if (sel < 2) doOp(1, 0, 3'd0, d, "R3 rnd data wr");
      else if (sel < 4) doOp(1, 0, 3'd2, d & 8'h3F, "R5 rnd ctrl wr");
      else if (sel < 8) doOp(0, 1, 3'd1, 8'h00, "R9 rnd status rd");
      else doOp(($urandom % 8) == 0, 1, 3'($urandom), d, "R2 rnd access");
    end
    finishRun();
  end
endmodule